// File: doc/BRIEF.md
# Multi-Cycle Master-Enable Tick Sequencer

This block paces a multi-cycle processor core that runs on a fast clock. The core's datapath stays purely combinational from one architectural state to the next. The sequencer only counts clock ticks. Each instruction class is given as many cycles as its slowest path needs through instruction memory, the register file, the ALU and data memory. Architectural state is written only when a single master-enable pulse fires, and that happens in the cycle where the combinational result has settled.

The decode logic supplies a 3-bit instruction class derived from the fetched opcode. The sequencer reads that class in the last fetch tick and keeps a copy of it for the rest of the instruction. It exposes its current control state, the master enable, and a retire strobe that a testbench can use to measure cycles per instruction. No other control signal passes through this block. The class input and the outputs are plain control pins with no handshake: the class is sampled unconditionally and nothing can stall the count.

Top module: `tick_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in state code 0 (first fetch tick) with `master_en_o` low. This applies on the first clock edge where `rst` is high, including in the middle of an instruction.
- R2: The state codes are: fetch ticks 0,1,2,3; decode 4; execute ticks 5,6; memory ticks 7,8,9,10; write-back 11. Fetch steps through 0→1→2→3. From state 3 the next state is 4, except for jump-and-link, which goes straight to state 5.
- R3: State 4 goes to 5, and 5 goes to 6. From state 6, ALU classes go to 11, loads and stores go to 7, and branches, register jumps and jump-and-link go to 0.
- R4: States 7→8→9→10 step in order. From state 10 a load goes to 11 and a store goes to 0. State 11 always goes to 0.
- R5: Measured from the first fetch tick to the cycle in which the master enable is high, inclusive, the cycles per instruction are: ALU 8, load 12, store 11, branch 7, register jump 7, jump-and-link 6.
- R6: `master_en_o` is high in exactly one cycle per instruction, and that cycle is the last one: state 6 for branch, register jump and jump-and-link; state 10 for store; state 11 for ALU and load. It is never high in two consecutive cycles.
- R7: `retire_o` equals `master_en_o` in every cycle.
- R8: The class codes on `cls_i` are: 0 ALU (R/I-type), 1 load, 2 store, 3 branch, 4 register jump, 5 jump-and-link. The class is taken from `cls_i` while the state is 3. After that, changes on `cls_i` have no effect on the state sequence or on the master enable for the rest of that instruction.
- R9: Class codes 6 and 7 are treated as ALU: they give the state path 0..3, 4, 5, 6, 11 and take 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 3 | Decoded instruction class, read in state 3 |
| state_o | output | 4 | Current control state code |
| master_en_o | output | 1 | Architectural-state write enable, high in an instruction's last cycle |
| retire_o | output | 1 | Instruction-retired strobe, equal to the master enable |

## Verification
The state register changes on each rising edge. The master enable and the retire strobe are decoded from that register and from the held class, so they are valid in the same cycle as the state code they belong to. The class is captured on the edge that leaves state 3. The bench therefore drives `cls_i` and samples every output on the falling edge: a value sampled in cycle N is compared with the state the model predicts for cycle N, and the count of cycles per instruction stops at the falling edge where the enable is first seen high. To prove that the held class is used, the bench changes `cls_i` to a wrong code on the falling edge right after state 3 and then confirms that the path and the count do not change.

// File: rtl/tick_seq_pkg.sv
package tick_seq_pkg;

  localparam int CLS_W = 3;
  localparam int ST_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU  = 3'd0,
    CLS_LOAD = 3'd1,
    CLS_STOR = 3'd2,
    CLS_BRAN = 3'd3,
    CLS_JREG = 3'd4,
    CLS_JLNK = 3'd5,
    CLS_RSV6 = 3'd6,
    CLS_RSV7 = 3'd7
  } cls_e;

  typedef enum logic [ST_W-1:0] {
    ST_F1  = 4'd0,
    ST_F2  = 4'd1,
    ST_F3  = 4'd2,
    ST_F4  = 4'd3,
    ST_DEC = 4'd4,
    ST_X1  = 4'd5,
    ST_X2  = 4'd6,
    ST_M1  = 4'd7,
    ST_M2  = 4'd8,
    ST_M3  = 4'd9,
    ST_M4  = 4'd10,
    ST_WB  = 4'd11
  } tick_state_e;

  // Fold the unused class codes onto the ALU class.
  function automatic cls_e norm_cls(input logic [CLS_W-1:0] raw);
    cls_e c;
    case (raw)
      3'd1:    c = CLS_LOAD;
      3'd2:    c = CLS_STOR;
      3'd3:    c = CLS_BRAN;
      3'd4:    c = CLS_JREG;
      3'd5:    c = CLS_JLNK;
      default: c = CLS_ALU;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tick_class_hold.sv
module tick_class_hold
  import tick_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [CLS_W-1:0] cls_raw_i,
  output cls_e             cls_eff_o
);

  cls_e held_q;
  cls_e live_c;

  assign live_c = norm_cls(cls_raw_i);

  always_ff @(posedge clk) begin
    if (rst)            held_q <= CLS_ALU;
    else if (capture_i) held_q <= live_c;
  end

  // In the capture cycle the live class steers the exit from fetch.
  assign cls_eff_o = capture_i ? live_c : held_q;

endmodule

// File: rtl/tick_next_state.sv
module tick_next_state
  import tick_seq_pkg::*;
(
  input  tick_state_e cur_i,
  input  cls_e        cls_i,
  output tick_state_e nxt_o
);

  always_comb begin
    case (cur_i)
      ST_F1:  nxt_o = ST_F2;
      ST_F2:  nxt_o = ST_F3;
      ST_F3:  nxt_o = ST_F4;
      ST_F4:  nxt_o = (cls_i == CLS_JLNK) ? ST_X1 : ST_DEC;
      ST_DEC: nxt_o = ST_X1;
      ST_X1:  nxt_o = ST_X2;
      ST_X2: begin
        case (cls_i)
          CLS_ALU:            nxt_o = ST_WB;
          CLS_LOAD, CLS_STOR: nxt_o = ST_M1;
          default:            nxt_o = ST_F1;
        endcase
      end
      ST_M1:  nxt_o = ST_M2;
      ST_M2:  nxt_o = ST_M3;
      ST_M3:  nxt_o = ST_M4;
      ST_M4:  nxt_o = (cls_i == CLS_LOAD) ? ST_WB : ST_F1;
      default: nxt_o = ST_F1;
    endcase
  end

endmodule

// File: rtl/tick_enable_dec.sv
module tick_enable_dec
  import tick_seq_pkg::*;
(
  input  tick_state_e cur_i,
  input  cls_e        cls_i,
  output logic        en_o
);

  logic ctl_xfer_c;

  assign ctl_xfer_c = (cls_i == CLS_BRAN) || (cls_i == CLS_JREG) ||
                      (cls_i == CLS_JLNK);

  always_comb begin
    case (cur_i)
      ST_X2:   en_o = ctl_xfer_c;
      ST_M4:   en_o = (cls_i == CLS_STOR);
      ST_WB:   en_o = 1'b1;
      default: en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tick_seq.sv
module tick_seq
  import tick_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CLS_W-1:0] cls_i,
  output logic [ST_W-1:0]  state_o,
  output logic             master_en_o,
  output logic             retire_o
);

  tick_state_e st_q;
  tick_state_e st_nxt;
  cls_e        cls_eff;
  logic        en_c;

  tick_class_hold u_hold (
    .clk       (clk),
    .rst       (rst),
    .capture_i (st_q == ST_F4),
    .cls_raw_i (cls_i),
    .cls_eff_o (cls_eff)
  );

  tick_next_state u_nxt (
    .cur_i (st_q),
    .cls_i (cls_eff),
    .nxt_o (st_nxt)
  );

  tick_enable_dec u_en (
    .cur_i (st_q),
    .cls_i (cls_eff),
    .en_o  (en_c)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_F1;
    else     st_q <= st_nxt;
  end

  assign state_o     = st_q;
  assign master_en_o = en_c;
  assign retire_o    = en_c;

endmodule

// File: rtl/tick_seq_chk.sv
module tick_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cls_i,
  input logic [3:0] state_o,
  input logic       master_en_o
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_o == 4'd0 && !master_en_o));

  // R2
  jlnk_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd3 && cls_i == 3'd5) |=> state_o == 4'd5);

  // R3
  ex_chain_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 4'd5 |=> state_o == 4'd6);

  // R4
  after_en_chk: assert property (@(posedge clk) disable iff (rst)
    master_en_o |=> state_o == 4'd0);

  // R6
  en_place_chk: assert property (@(posedge clk) disable iff (rst)
    master_en_o |-> (state_o == 4'd6 || state_o == 4'd10 || state_o == 4'd11));

  // R6
  en_single_chk: assert property (@(posedge clk) disable iff (rst)
    master_en_o |=> !master_en_o);

  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (rst)
    state_o <= 4'd11);

endmodule

bind tick_seq tick_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cls_i       (cls_i),
  .state_o     (state_o),
  .master_en_o (master_en_o)
);

// File: tb/tick_seq_tb.sv
module tick_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cls = 3'd0;
  logic [3:0] state;
  logic       me;
  logic       ret;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  tick_seq u_dut (
    .clk         (clk),
    .rst         (rst),
    .cls_i       (cls),
    .state_o     (state),
    .master_en_o (me),
    .retire_o    (ret)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    return (c > 5) ? 0 : c;
  endfunction

  // R5 cycle count built from the phases each class visits
  function automatic int cpi_of(input int c);
    int k = eff(c);
    int n = 4 + 2;
    if (k != 5) n += 1;
    if (k == 1 || k == 2) n += 4;
    if (k == 0 || k == 1) n += 1;
    return n;
  endfunction

  function automatic int nxt_of(input int s, input int c);
    int k = eff(c);
    case (s)
      3: return (k == 5) ? 5 : 4;
      6: return (k == 0) ? 11 : ((k == 1 || k == 2) ? 7 : 0);
      10: return (k == 1) ? 11 : 0;
      11: return 0;
      default: return s + 1;
    endcase
  endfunction

  function automatic int last_of(input int c);
    int k = eff(c);
    if (k == 2) return 10;
    if (k == 0 || k == 1) return 11;
    return 6;
  endfunction

  // Runs one instruction; starts and ends at a falling edge with state 0 expected.
  task automatic run_instr(input int c, input bit scramble);
    int exp_s = 0;
    int cyc = 0;
    bit done = 0;
    cls = c[2:0];
    while (!done && cyc < 20) begin
      cyc++;
      check("R2 state path", int'(state), exp_s);
      check("R7 retire equals enable", int'(ret), int'(me));
      if (exp_s == last_of(c)) begin
        check("R6 enable in final cycle", int'(me), 1);
        check("R5 cycles per instruction", cyc, cpi_of(c));
        if (c > 5) check("R9 reserved code as ALU", cyc, 8);
        done = 1;
      end else if (me) begin
        check("R6 enable early", int'(me), 0);
        done = 1;
      end
      if (scramble && exp_s == 3) begin
        @(posedge clk); @(negedge clk);
        cls = 3'(c + 3);
      end else begin
        @(posedge clk); @(negedge clk);
      end
      exp_s = nxt_of(exp_s, c);
    end
    if (!done) check("R5 instruction never retired", cyc, cpi_of(c));
    check("R4 return to first fetch", int'(state), 0);
    check("R6 enable low after retire", int'(me), 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset state", int'(state), 0);
    check("R1 reset enable", int'(me), 0);
    rst = 1'b0;

    // every class alone, held input
    for (int c = 0; c < 8; c++) run_instr(c, 1'b0);
    // R8 input changed after capture
    for (int c = 0; c < 8; c++) run_instr(c, 1'b1);
    // back-to-back pairs over all codes
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        run_instr(a, 1'b1);
        run_instr(b, 1'b0);
      end

    // R1 reset in the middle of a load
    cls = 3'd1;
    repeat (8) begin @(posedge clk); end
    @(negedge clk);
    check("R1 mid-run precondition", int'(state) > 3 ? 1 : 0, 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 mid-run reset state", int'(state), 0);
    check("R1 mid-run reset enable", int'(me), 0);
    rst = 1'b0;
    run_instr(3, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule